// File: doc/BRIEF.md
# SDR SDRAM Bring-Up and Refresh Sequencer

This block takes a single-rank SDR SDRAM from power-up to an operational state and then keeps its contents alive. When reset is released it raises the clock-enable pin, holds the command bus at no-operation for a programmable power-up delay, and then precharges all banks. Next it issues a fixed number of auto-refresh commands and loads the mode register. Every gap between these commands is a parameter counted in memory clocks. When the mode load and its settle gap are complete, it raises a ready flag.

After that, an interval timer raises a refresh request once per refresh period. The period is nominally 7.8 µs, which is 702 clocks at 90 MHz. A request is served only in a cycle when the user-side access engine reports it is idle. While a refresh is settling, the block holds the engine off. Requests that arrive while the engine is busy are queued, up to two of them. A third unserved request sets a sticky overflow flag.

The block drives the raw command pins (chip select, row strobe, column strobe, write enable, clock enable) together with the address and bank lines. The data path and user row management belong to other blocks.

Top module: `sdr_bringup_seq`

## Requirements
- R1: While reset is asserted, mem_cke is 0, {cs_n,ras_n,cas_n,we_n} is 1111 (deselect), and ready, ref_hold and ref_overflow are all 0.
- R2: mem_cke rises on the first clock after reset is released. The precharge-all command follows exactly PWRUP_CYC cycles after mem_cke rises.
- R3: Once mem_cke is high, every cycle that carries no command shows NOP, which is {cs_n,ras_n,cas_n,we_n} = 0111. No other encoding appears.
- R4: Precharge-all is encoded as 0010 and drives address bit 10 high.
- R5: Auto-refresh is encoded as 0001. During bring-up exactly INIT_REFRESHES of them are issued. The first comes T_RP cycles after the precharge, and each later one comes T_RC cycles after the one before it.
- R6: Mode-register load is encoded as 0000. It comes T_RC cycles after the last bring-up refresh. It drives mem_ba = 0 and mem_addr = 0x231: bits 2..0 = 001 select burst 2, bit 3 = 0 selects sequential order, bits 6..4 = 011 select CAS latency 3, bits 8..7 = 00 select standard mode, and bit 9 = 1 selects single-location writes.
- R7: ready rises exactly T_MRD cycles after the mode load and never falls again. The mode load is issued only once.
- R8: After ready, a refresh request is raised every REF_INTERVAL cycles. The first request comes REF_INTERVAL cycles after ready rises. With the engine idle, each request is served by a refresh one cycle after it is raised.
- R9: A run-time refresh is issued only if eng_idle was high in the cycle before it. A request raised while eng_idle is low is kept and is served once eng_idle returns.
- R10: After each run-time refresh, ref_hold is high for T_RC-1 cycles. Two queued requests are served by refreshes exactly T_RC cycles apart.
- R11: Two unserved requests do not set ref_overflow. A third request raised while two are still queued sets ref_overflow, which stays high until reset. Only two refreshes are then served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_idle | input | 1 | User access engine is idle and allows a refresh |
| mem_cke | output | 1 | SDRAM clock enable |
| mem_cs_n | output | 1 | SDRAM chip select, active low |
| mem_ras_n | output | 1 | SDRAM row strobe, active low |
| mem_cas_n | output | 1 | SDRAM column strobe, active low |
| mem_we_n | output | 1 | SDRAM write enable, active low |
| mem_addr | output | ROW_W | SDRAM address lines |
| mem_ba | output | BANK_W | SDRAM bank select lines |
| ready | output | 1 | Bring-up finished; user traffic may start |
| ref_hold | output | 1 | Refresh settling; engine must not issue commands |
| ref_overflow | output | 1 | Sticky: a refresh request was lost |

## Verification
The bench builds the block with PWRUP_CYC = 50 and REF_INTERVAL = 40. This replaces the 100 ms wait and the 702-clock period, so bring-up and many refresh periods fit in a few hundred cycles. T_RP, T_RC and T_MRD keep their 90 MHz values (2, 7, 2), and INIT_REFRESHES stays at 4, so every bring-up gap is measured at the real cycle count. With the short interval, the bench can hold the engine busy across two and then three request periods, which reaches the queue-full and overflow cases directly.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   // Command encodings, packed as {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_DESEL = 4'b1111,
      CMD_NOP   = 4'b0111,
      CMD_PRE   = 4'b0010,
      CMD_REF   = 4'b0001,
      CMD_MRS   = 4'b0000
   } sdr_cmd_e;

   typedef enum logic [2:0] {
      ST_PWRUP,
      ST_PRE_W,
      ST_IREF,
      ST_MRS_W,
      ST_RUN
   } seq_state_e;

   // Mode word: single-location writes, standard mode, CAS latency, sequential order, burst code
   function automatic logic [9:0] mode_word(input int burst_len, input int cas_lat);
      logic [2:0] bl_code;
      case (burst_len)
         1:       bl_code = 3'd0;
         2:       bl_code = 3'd1;
         4:       bl_code = 3'd2;
         default: bl_code = 3'd3;
      endcase
      return {1'b1, 2'b00, 3'(cas_lat), 1'b0, bl_code};
   endfunction

endpackage

// File: rtl/sdr_ref_sched.sv
module sdr_ref_sched #(
   parameter int REF_INTERVAL = 702
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic take,
   output logic pend,
   output logic ovf
);
   localparam int CW = $clog2(REF_INTERVAL + 1);

   logic [CW-1:0] cnt_q;
   logic [1:0]    pend_q;
   logic          ovf_q;
   logic          tick;

   assign tick = en && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= CW'(REF_INTERVAL - 1);
         pend_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (en) begin
            cnt_q <= (cnt_q == '0) ? CW'(REF_INTERVAL - 1) : cnt_q - 1'b1;
         end
         case ({tick, take})
            2'b10: begin
               if (pend_q == 2'd2) ovf_q <= 1'b1;
               else                pend_q <= pend_q + 1'b1;
            end
            2'b01:   pend_q <= pend_q - 1'b1;
            default: ;
         endcase
      end
   end

   assign pend = (pend_q != '0);
   assign ovf  = ovf_q;
endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
   import sdr_seq_pkg::*;
#(
   parameter int ROW_W          = 13,
   parameter int BANK_W         = 2,
   parameter int PWRUP_CYC      = 9_000_000,
   parameter int INIT_REFRESHES = 4,
   parameter int T_RP           = 2,
   parameter int T_RC           = 7,
   parameter int T_MRD          = 2,
   parameter int BURST_LEN      = 2,
   parameter int CAS_LAT        = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_idle,
   input  logic              pend,
   output logic              take,
   output logic              cke,
   output logic [3:0]        cmd,
   output logic [ROW_W-1:0]  addr,
   output logic [BANK_W-1:0] ba,
   output logic              ready,
   output logic              hold
);
   localparam int WAIT_W = $clog2(PWRUP_CYC + 17);
   localparam int RCNT_W = $clog2(INIT_REFRESHES + 1);
   localparam logic [ROW_W-1:0] MODE_VAL = ROW_W'(mode_word(BURST_LEN, CAS_LAT));

   seq_state_e        st_q;
   logic [WAIT_W-1:0] wait_q;
   logic [RCNT_W-1:0] rcnt_q;
   logic              cke_q, ready_q;
   sdr_cmd_e          cmd_q;
   logic [ROW_W-1:0]  addr_q;
   logic              gap_done;

   assign gap_done = (wait_q == '0);
   assign take     = (st_q == ST_RUN) && pend && eng_idle && gap_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_PWRUP;
         wait_q  <= WAIT_W'(PWRUP_CYC);
         rcnt_q  <= '0;
         cke_q   <= 1'b0;
         ready_q <= 1'b0;
         cmd_q   <= CMD_DESEL;
         addr_q  <= '0;
      end else begin
         cke_q  <= 1'b1;
         cmd_q  <= CMD_NOP;
         addr_q <= '0;
         if (!gap_done) wait_q <= wait_q - 1'b1;
         case (st_q)
            ST_PWRUP: if (gap_done) begin
               cmd_q      <= CMD_PRE;
               addr_q[10] <= 1'b1;
               wait_q     <= WAIT_W'(T_RP - 1);
               st_q       <= ST_PRE_W;
            end
            ST_PRE_W: if (gap_done) begin
               cmd_q  <= CMD_REF;
               rcnt_q <= RCNT_W'(1);
               wait_q <= WAIT_W'(T_RC - 1);
               st_q   <= ST_IREF;
            end
            ST_IREF: if (gap_done) begin
               if (rcnt_q == RCNT_W'(INIT_REFRESHES)) begin
                  cmd_q  <= CMD_MRS;
                  addr_q <= MODE_VAL;
                  wait_q <= WAIT_W'(T_MRD - 1);
                  st_q   <= ST_MRS_W;
               end else begin
                  cmd_q  <= CMD_REF;
                  rcnt_q <= rcnt_q + 1'b1;
                  wait_q <= WAIT_W'(T_RC - 1);
               end
            end
            ST_MRS_W: if (gap_done) begin
               ready_q <= 1'b1;
               st_q    <= ST_RUN;
            end
            ST_RUN: if (take) begin
               cmd_q  <= CMD_REF;
               wait_q <= WAIT_W'(T_RC - 1);
            end
            default: st_q <= ST_PWRUP;
         endcase
      end
   end

   generate
      if (T_RC > 1) begin : g_hold
         logic hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    hold_q <= 1'b0;
            else if (take) hold_q <= 1'b1;
            else           hold_q <= (wait_q > WAIT_W'(1));
         end
         assign hold = hold_q;
      end else begin : g_nohold
         assign hold = 1'b0;
      end
   endgenerate

   assign cke   = cke_q;
   assign cmd   = cmd_q;
   assign addr  = addr_q;
   assign ba    = '0;
   assign ready = ready_q;
endmodule

// File: rtl/sdr_bringup_seq.sv
module sdr_bringup_seq #(
   parameter int ROW_W          = 13,
   parameter int BANK_W         = 2,
   parameter int PWRUP_CYC      = 9_000_000,
   parameter int REF_INTERVAL   = 702,
   parameter int INIT_REFRESHES = 4,
   parameter int T_RP           = 2,
   parameter int T_RC           = 7,
   parameter int T_MRD          = 2,
   parameter int BURST_LEN      = 2,
   parameter int CAS_LAT        = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_idle,
   output logic              mem_cke,
   output logic              mem_cs_n,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [ROW_W-1:0]  mem_addr,
   output logic [BANK_W-1:0] mem_ba,
   output logic              ready,
   output logic              ref_hold,
   output logic              ref_overflow
);
   if (ROW_W < 11)                            begin : g_bad_row  $error("ROW_W must be at least 11"); end
   if (T_RP < 1 || T_RP > 16)                 begin : g_bad_rp   $error("T_RP outside 1..16"); end
   if (T_RC < 1 || T_RC > 16)                 begin : g_bad_rc   $error("T_RC outside 1..16"); end
   if (T_MRD < 1 || T_MRD > 16)               begin : g_bad_mrd  $error("T_MRD outside 1..16"); end
   if (PWRUP_CYC < 1)                         begin : g_bad_pw   $error("PWRUP_CYC must be positive"); end
   if (INIT_REFRESHES < 1)                    begin : g_bad_ir   $error("INIT_REFRESHES must be positive"); end
   if (REF_INTERVAL <= T_RC)                  begin : g_bad_ri   $error("REF_INTERVAL must exceed T_RC"); end
   if (CAS_LAT < 1 || CAS_LAT > 3)            begin : g_bad_cl   $error("CAS_LAT outside 1..3"); end
   if (!(BURST_LEN inside {1, 2, 4, 8}))      begin : g_bad_bl   $error("BURST_LEN must be 1, 2, 4 or 8"); end

   logic       pend, take;
   logic [3:0] cmd;

   sdr_ref_sched #(.REF_INTERVAL(REF_INTERVAL)) u_sched (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ready),
      .take (take),
      .pend (pend),
      .ovf  (ref_overflow)
   );

   sdr_cmd_seq #(
      .ROW_W(ROW_W), .BANK_W(BANK_W), .PWRUP_CYC(PWRUP_CYC),
      .INIT_REFRESHES(INIT_REFRESHES), .T_RP(T_RP), .T_RC(T_RC),
      .T_MRD(T_MRD), .BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .eng_idle(eng_idle),
      .pend    (pend),
      .take    (take),
      .cke     (mem_cke),
      .cmd     (cmd),
      .addr    (mem_addr),
      .ba      (mem_ba),
      .ready   (ready),
      .hold    (ref_hold)
   );

   assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;
endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
   parameter int ROW_W = 13,
   parameter int T_RC  = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             eng_idle,
   input logic             cke,
   input logic [3:0]       cmd,
   input logic [ROW_W-1:0] addr,
   input logic             ready,
   input logic             ovf
);
   logic is_ref, is_pre, is_mrs;
   logic [4:0] since_ref_q;

   assign is_ref = (cmd == 4'b0001);
   assign is_pre = (cmd == 4'b0010);
   assign is_mrs = (cmd == 4'b0000);

   always_ff @(posedge clk) begin
      if (!rst_n)                  since_ref_q <= 5'd31;
      else if (is_ref)             since_ref_q <= 5'd0;
      else if (since_ref_q != 31)  since_ref_q <= since_ref_q + 5'd1;
   end

   // R2
   cke_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> cmd == 4'b1111);
   // R4
   pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> addr[10]);
   // R5
   ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> (int'(since_ref_q) >= T_RC - 1));
   // R7
   ready_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);
   // R7
   mrs_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |-> !ready);
   // R9
   ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready) && is_ref) |-> $past(eng_idle));
   // R11
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
endmodule

bind sdr_bringup_seq sdr_seq_checker #(.ROW_W(ROW_W), .T_RC(T_RC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .eng_idle(eng_idle),
   .cke     (mem_cke),
   .cmd     ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}),
   .addr    (mem_addr),
   .ready   (ready),
   .ovf     (ref_overflow)
);

// File: tb/sdr_bringup_seq_bench.sv
`timescale 1ns/1ps
module sdr_bringup_seq_bench;
   localparam int PW  = 50;
   localparam int RI  = 40;
   localparam int NIR = 4;
   localparam int TRP = 2;
   localparam int TRC = 7;
   localparam int TMR = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eng_idle = 1'b1;
   logic mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
   logic [12:0] mem_addr;
   logic [1:0]  mem_ba;
   logic ready, ref_hold, ref_overflow;

   always #2.5 clk = ~clk;

   sdr_bringup_seq #(
      .PWRUP_CYC(PW), .REF_INTERVAL(RI), .INIT_REFRESHES(NIR),
      .T_RP(TRP), .T_RC(TRC), .T_MRD(TMR)
   ) u_sdr_bringup_seq (
      .clk(clk), .rst_n(rst_n), .eng_idle(eng_idle),
      .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
      .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
      .mem_ba(mem_ba), .ready(ready), .ref_hold(ref_hold),
      .ref_overflow(ref_overflow)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit done = 0;

   // monitor state
   int cke_cyc = -1, pre_cyc = -1, mrs_cyc = -1, ready_cyc = -1, rel_cyc = 0;
   int n_ref = 0, n_mrs = 0, n_bad = 0, ready_drop = 0;
   int hold_run = 0, last_hold = -1;
   int ref_cyc [64];
   logic pre_a10 = 1'b0;
   logic [12:0] mrs_addr = '0;
   logic [1:0]  mrs_ba = '0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cke_cyc < 0 && mem_cke) cke_cyc = cyc;
         case ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n})
            4'b0111: ;
            4'b0010: begin pre_cyc = cyc; pre_a10 = mem_addr[10]; end
            4'b0001: begin if (n_ref < 64) ref_cyc[n_ref] = cyc; n_ref++; end
            4'b0000: begin mrs_cyc = cyc; mrs_addr = mem_addr; mrs_ba = mem_ba; n_mrs++; end
            4'b1111: if (mem_cke) n_bad++;
            default: n_bad++;
         endcase
         if (ready && ready_cyc < 0) ready_cyc = cyc;
         if (!ready && ready_cyc >= 0) ready_drop++;
         if (ref_hold) hold_run++;
         else if (hold_run != 0) begin last_hold = hold_run; hold_run = 0; end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic t_reset;
      repeat (4) @(negedge clk);
      // R1
      chk("R1", "cke in reset", int'(mem_cke), 0);
      chk("R1", "command in reset", int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), 15);
      chk("R1", "ready in reset", int'(ready), 0);
      chk("R1", "hold in reset", int'(ref_hold), 0);
      chk("R1", "overflow in reset", int'(ref_overflow), 0);
      rel_cyc = cyc;
      rst_n = 1'b1;
   endtask

   task automatic t_init;
      wait (ready_cyc >= 0);
      @(negedge clk);
      chk("R2", "cke rise cycle", cke_cyc - rel_cyc, 1);
      chk("R2", "cke to precharge", pre_cyc - cke_cyc, PW);
      chk("R4", "precharge A10", int'(pre_a10), 1);
      chk("R5", "bring-up refresh count", n_ref, NIR);
      chk("R5", "precharge to first refresh", ref_cyc[0] - pre_cyc, TRP);
      for (int i = 1; i < NIR; i++)
         chk("R5", "refresh to refresh", ref_cyc[i] - ref_cyc[i-1], TRC);
      chk("R6", "last refresh to mode load", mrs_cyc - ref_cyc[NIR-1], TRC);
      chk("R6", "mode word", int'(mrs_addr), 'h231);
      chk("R6", "mode bank", int'(mrs_ba), 0);
      chk("R7", "mode load to ready", ready_cyc - mrs_cyc, TMR);
      chk("R3", "non-NOP idle cycles", n_bad, 0);
   endtask

   task automatic t_periodic;
      wait (n_ref >= NIR + 2);
      repeat (TRC + 2) @(negedge clk);
      chk("R8", "ready to first periodic refresh", ref_cyc[NIR] - ready_cyc, RI + 1);
      chk("R8", "periodic spacing", ref_cyc[NIR+1] - ref_cyc[NIR], RI);
      chk("R10", "hold length", last_hold, TRC - 1);
   endtask

   task automatic t_busy;
      int k;
      k = n_ref;
      wait (n_ref > k);
      @(negedge clk);
      k = n_ref;
      eng_idle = 1'b0;
      repeat (2*RI + 5) @(negedge clk);
      chk("R9", "no refresh while busy", n_ref, k);
      chk("R11", "two queued, no overflow", int'(ref_overflow), 0);
      eng_idle = 1'b1;
      repeat (RI/2) @(negedge clk);
      chk("R9", "queued refreshes served", n_ref, k + 2);
      chk("R10", "queued refresh spacing", ref_cyc[k+1] - ref_cyc[k], TRC);
   endtask

   task automatic t_overflow;
      int k;
      k = n_ref;
      wait (n_ref > k);
      @(negedge clk);
      k = n_ref;
      eng_idle = 1'b0;
      repeat (3*RI + 5) @(negedge clk);
      chk("R11", "overflow after third request", int'(ref_overflow), 1);
      chk("R9", "no refresh while busy", n_ref, k);
      eng_idle = 1'b1;
      repeat (RI/2) @(negedge clk);
      chk("R11", "only two served", n_ref, k + 2);
      chk("R11", "overflow sticky", int'(ref_overflow), 1);
      chk("R7", "ready never dropped", ready_drop, 0);
      chk("R7", "single mode load", n_mrs, 1);
      chk("R3", "non-NOP idle cycles overall", n_bad, 0);
   endtask

   initial begin
      t_reset();
      t_init();
      t_periodic();
      t_busy();
      t_overflow();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule